// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block sits on the controller side of an I2C bus. It frees a bus that a target has left stuck, usually because the controller was reset partway through a transfer while the target was still driving SDA low. Software or the reset sequencer pulses `recover_req` during initialisation, before any normal traffic, and then waits for `done` or `fail`.

Both bus lines are treated as open-drain. The block only pulls a line low or releases it, and it reads the real line levels back through a two-flop synchroniser. It first waits for SCL to be high. It then samples SDA near the end of each SCL high phase. While SDA stays low, it adds one more SCL pulse, up to a fixed maximum. As soon as SDA reads high, it makes a START and then a STOP, which returns every target to idle. If SDA never frees, the block reports `fail`. It also reports `fail` if a target holds SCL low beyond a cycle limit.

All pins are plain control and status signals. No data flows through the block, so there is no valid/ready handshake.

Top module: `i2c_bus_unjam`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `scl_pull_low`, `sda_pull_low`, `busy`, `done` and `fail` are all 0.
- R2: A `recover_req` sampled high while idle makes `busy` 1 from the next cycle. `busy` stays 1 until the cycle in which `done` or `fail` is 1, and it is 0 in that cycle.
- R3: One recovery makes at most `MAX_PULSES` (default 9) SCL pulses. A pulse is one rising edge of `scl_pull_low`. Each pulse holds SCL low for `HALF_CYCLES` clocks.
- R4: SDA is sampled at the end of each SCL high phase. A further pulse is made only when that sample was low. If a target frees SDA on its Nth SCL rise, with N no larger than `MAX_PULSES`, exactly N pulses are made.
- R5: If SDA is already high when the request is accepted, no SCL pulse is made, and the START and STOP follow directly.
- R6: After SDA is seen high, the block makes a START: `sda_pull_low` rises while SCL is high. It then makes a STOP: `sda_pull_low` falls while SCL is high. After that, `done` is 1 for exactly one cycle.
- R7: If SDA is still low after the last permitted pulse, `fail` is 1 for exactly one cycle. No START or STOP is made, and both lines are released.
- R8: The block counts clocks while it waits for SCL to read high. If the wait reaches `STRETCH_LIMIT` (default 64), the recovery ends with `fail`. A shorter hold of SCL low only delays the sequence.
- R9: A `recover_req` sampled while `busy` is 1 is ignored. It neither restarts nor queues a second recovery.
- R10: Whenever `busy` is 0, both pull-low outputs are 0. SCL and SDA are only read through the two-stage synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| recover_req | input | 1 | Start a recovery; taken only while idle |
| scl_in | input | 1 | Actual SCL line level |
| sda_in | input | 1 | Actual SDA line level |
| scl_pull_low | output | 1 | 1 = pull SCL low, 0 = release |
| sda_pull_low | output | 1 | 1 = pull SDA low, 0 = release |
| busy | output | 1 | Recovery in progress |
| done | output | 1 | One-cycle pulse: bus freed, START and STOP sent |
| fail | output | 1 | One-cycle pulse: SDA never freed, or SCL stretch timeout |

## Verification
The embedded assertions check the following on every cycle:
- the pulse count never exceeds its bound;
- a new pulse begins only after a low SDA sample;
- SDA is pulled low only while SCL reads high;
- `done` and `fail` are single-cycle and never coincide;
- the lines are released whenever the block is idle.

Only the bench scenarios can show the rest. They cover:
- the exact number of pulses for targets that free SDA after different numbers of clocks;
- the zero-pulse path when SDA is already free;
- the failure after the pulse limit runs out;
- the difference between a short SCL stretch and a timeout;
- that a request made during a recovery is not queued.

// File: rtl/unjam_pkg.sv
package unjam_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_HI,
    ST_HIGH,
    ST_LOW,
    ST_START,
    ST_STOP,
    ST_DONE,
    ST_FAIL
  } unjam_state_e;
endpackage

// File: rtl/line_sync.sv
module line_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw,
  output logic [WIDTH-1:0] synced
);
  // released open-drain lines idle high, so the chain resets to ones
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= raw;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign synced = chain[STAGES-1];
endmodule

// File: rtl/cycle_counter.sv
module cycle_counter #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic hit
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT + 1) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  // counts from 0 after clr and saturates at LIMIT-1
  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clr)     cnt_q <= '0;
    else if (!hit)    cnt_q <= cnt_q + 1'b1;
  end

  assign hit = (cnt_q == LAST);
endmodule

// File: rtl/i2c_bus_unjam.sv
module i2c_bus_unjam
  import unjam_pkg::*;
#(
  parameter int HALF_CYCLES   = 4,
  parameter int MAX_PULSES    = 9,
  parameter int STRETCH_LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic recover_req,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_pull_low,
  output logic sda_pull_low,
  output logic busy,
  output logic done,
  output logic fail
);
  localparam int PW = $clog2(MAX_PULSES + 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(MAX_PULSES);

  unjam_state_e state_q, state_d;
  logic [PW-1:0] pulses_q;
  logic [1:0]    lines_s;
  logic          scl_s, sda_s;
  logic          phase_hit, stretch_hit, step;

  line_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   ({scl_in, sda_in}),
    .synced(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  // both timers restart whenever the state changes
  assign step = (state_q != state_d);

  cycle_counter #(.LIMIT(HALF_CYCLES)) u_phase (
    .clk(clk), .rst_n(rst_n), .clr(step), .hit(phase_hit)
  );

  cycle_counter #(.LIMIT(STRETCH_LIMIT)) u_stretch (
    .clk(clk), .rst_n(rst_n), .clr(step), .hit(stretch_hit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (recover_req) state_d = ST_WAIT_HI;
      ST_WAIT_HI: begin
        if (scl_s)            state_d = ST_HIGH;
        else if (stretch_hit) state_d = ST_FAIL;
      end
      ST_HIGH: if (phase_hit) begin
        if (sda_s)                        state_d = ST_START;
        else if (pulses_q == PULSE_LAST)  state_d = ST_FAIL;
        else                              state_d = ST_LOW;
      end
      ST_LOW:   if (phase_hit) state_d = ST_WAIT_HI;
      ST_START: if (phase_hit) state_d = ST_STOP;
      ST_STOP:  if (phase_hit) state_d = ST_DONE;
      ST_DONE:  state_d = ST_IDLE;
      ST_FAIL:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      pulses_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && recover_req)
        pulses_q <= '0;
      else if (state_q == ST_HIGH && state_d == ST_LOW)
        pulses_q <= pulses_q + 1'b1;
    end
  end

  assign scl_pull_low = (state_q == ST_LOW);
  assign sda_pull_low = (state_q == ST_START);
  assign busy = (state_q != ST_IDLE) && (state_q != ST_DONE) && (state_q != ST_FAIL);
  assign done = (state_q == ST_DONE);
  assign fail = (state_q == ST_FAIL);

  assert_pulse_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulses_q <= PULSE_LAST);

  assert_pulse_only_when_stuck_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_low) |-> !$past(sda_s));

  assert_start_with_scl_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_low) |-> scl_s);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_fail_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);

  assert_outcome_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));

  assert_busy_from_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(recover_req));

  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull_low && !sda_pull_low));
endmodule

// File: tb/sim_i2c_bus_unjam.sv
module sim_i2c_bus_unjam;
  localparam time CLK_PERIOD = 10ns;
  localparam int  HALF = 4;
  localparam int  MAXP = 9;
  localparam int  SLIM = 64;

  // columns: release-after-rise K (0 = SDA free), stretch cycles, expected pulses, expect done
  localparam int NV = 9;
  localparam int VEC [NV][4] = '{
    '{0,   0,   0, 1},
    '{1,   0,   1, 1},
    '{3,   0,   3, 1},
    '{8,   0,   8, 1},
    '{9,   0,   9, 1},
    '{10,  0,   9, 0},
    '{255, 0,   9, 0},
    '{2,   20,  2, 1},
    '{4,   200, 0, 0}
  };

  logic clk = 0, rst_n = 0, recover_req = 0;
  logic stretch = 0, sda_hold = 0;
  logic scl_line, sda_line;
  logic scl_pull_low, sda_pull_low, busy, done, fail;
  int hold_k = 0, rises = 0, pulses = 0, starts = 0, stops = 0;
  int done_cnt = 0, fail_cnt = 0, checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = !(scl_pull_low || stretch);
  assign sda_line = !(sda_pull_low || sda_hold);

  i2c_bus_unjam #(.HALF_CYCLES(HALF), .MAX_PULSES(MAXP), .STRETCH_LIMIT(SLIM)) u0 (
    .clk(clk), .rst_n(rst_n), .recover_req(recover_req),
    .scl_in(scl_line), .sda_in(sda_line),
    .scl_pull_low(scl_pull_low), .sda_pull_low(sda_pull_low),
    .busy(busy), .done(done), .fail(fail)
  );

  // target model: frees SDA on its K-th clock rise caused by the controller
  always @(negedge scl_pull_low) begin
    rises++;
    if (hold_k > 0 && rises >= hold_k) sda_hold = 0;
  end
  always @(posedge scl_pull_low) pulses++;
  always @(posedge sda_pull_low) if (scl_line) starts++;
  always @(negedge sda_pull_low) if (scl_line) stops++;
  always @(negedge clk) begin
    if (done) done_cnt++;
    if (fail) fail_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  task automatic run_case(input int k, input int st, input int exp_p, input int exp_ok);
    sda_hold = (k > 0);
    hold_k = k; rises = 0; pulses = 0; starts = 0; stops = 0;
    done_cnt = 0; fail_cnt = 0;
    stretch = (st > 0);
    if (st > 0) fork
      begin repeat (st) @(negedge clk); stretch = 0; end
    join_none
    @(negedge clk) recover_req = 1;
    @(negedge clk) recover_req = 0;
    chk(busy === 1'b1, "R2 busy after request", busy, 1);
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    chk((done || fail) && !busy, "R2 busy low at outcome", busy, 0);
    repeat (4) @(negedge clk);
    chk(pulses == exp_p, "R3/R4 pulse count", pulses, exp_p);
    chk(done_cnt == exp_ok, "R6 done pulses", done_cnt, exp_ok);
    chk(fail_cnt == 1 - exp_ok, "R7/R8 fail pulses", fail_cnt, 1 - exp_ok);
    chk(starts == exp_ok && stops == exp_ok, "R6 START/STOP count", starts + stops, 2 * exp_ok);
    chk(!scl_pull_low && !sda_pull_low, "R10 lines released", scl_pull_low + sda_pull_low, 0);
    wait (stretch == 0);
    sda_hold = 0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!scl_pull_low && !sda_pull_low, "R1 lines released in reset", scl_pull_low + sda_pull_low, 0);
    chk(!busy && !done && !fail, "R1 status low in reset", busy + done + fail, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !fail, "R1 status low after reset", busy + done + fail, 0);
    chk(!scl_pull_low && !sda_pull_low, "R1 lines released after reset", scl_pull_low + sda_pull_low, 0);

    for (int v = 0; v < NV; v++) run_case(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

    // R5: already-free bus gives no pulse but a START and a STOP
    run_case(0, 0, 0, 1);

    // R9: a second request during a recovery is ignored
    sda_hold = 1; hold_k = 3; rises = 0; pulses = 0; done_cnt = 0; fail_cnt = 0;
    starts = 0; stops = 0;
    @(negedge clk) recover_req = 1;
    @(negedge clk) recover_req = 0;
    repeat (6) @(negedge clk);
    recover_req = 1;
    @(negedge clk) recover_req = 0;
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(!busy, "R9 no queued recovery", busy, 0);
    chk(done_cnt == 1, "R9 single completion", done_cnt, 1);
    chk(pulses == 3, "R9 pulse count unchanged", pulses, 3);
    chk(starts == 1, "R9 single START", starts, 1);

    finish_up();
  end
endmodule